// File: doc/BRIEF.md
# Tamper Input Detector with Sample Filtering

This block watches a single external tamper pin and raises a sticky tamper flag when the pin shows an intrusion. It has two detection styles. The first fires on a single chosen transition of the pin. The second samples the pin at a programmable rate and fires only after a run of consecutive samples at the active level. In the sampled style, the block can drive a pull-up enable for a programmable number of clocks right before each sample, so that a capacitive pin settles before it is read.

The block also holds a small bank of backup data registers. Software writes and reads them through a simple port. Any tamper event erases the whole bank at the same clock edge that sets the flag. Software is expected to turn detection off while it writes the bank. If a write and an erase still meet in one cycle, the erase wins.

The raw pin passes through a two-flop synchronizer before it is evaluated. The asynchronous reset is released through a two-flop synchronizer inside the block.

Top module: `tamper_guard`

## Requirements
- R1: When `filt_sel` is 0 the block is in transition mode. With `pol` = 0 only a low-to-high pin change is an event; with `pol` = 1 only a high-to-low change is an event. The opposite change leaves the flag clear.
- R2: In transition mode, a pin change driven between clock edges appears on `tamper_flag` after the third following rising clock edge, not earlier (two synchronizer flops, then the flag register).
- R3: `pu_en` stays 0 at all times in transition mode, whenever `pu_off` is 1, and whenever `det_en` is 0.
- R4: A `filt_sel` of 1, 2 or 3 selects sampled mode and needs 2, 4 or 8 consecutive active samples. The active level is high for `pol` = 0 and low for `pol` = 1. The flag is set at the clock edge that ends the sample cycle completing the run.
- R5: A sample at the inactive level restarts the consecutive count from zero.
- R6: In sampled mode, samples are taken every 2^(RATE_BASE + `rate_sel`) clocks.
- R7: With `det_en` = 1, sampled mode and `pu_off` = 0, `pu_en` is high for exactly 2^`pch_sel` clocks. These clocks end directly before each sample cycle, and the sample cycle is the first clock in which `pu_en` is low again.
- R8: `tamper_flag` holds at 1 until `flag_clr` is pulsed. A tamper event in the same cycle as `flag_clr` keeps the flag set.
- R9: A tamper event clears every backup register at the edge that sets the flag. A write in that same cycle is lost.
- R10: When `wr_en` is 1, `wr_data` is stored at `wr_addr`. `rd_data` shows the register selected by `rd_addr` in the same cycle.
- R11: With `det_en` = 0, no pin activity sets the flag, and the consecutive count is held at zero.
- R12: During and after reset, the flag is 0, `pu_en` is 0 and every backup register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en | input | 1 | Detection enable |
| filt_sel | input | 2 | 0 = transition mode; 1/2/3 = sampled mode needing 2/4/8 samples |
| pol | input | 1 | 0 = rising edge / high level active; 1 = falling edge / low level active |
| rate_sel | input | 3 | Sample interval exponent offset |
| pch_sel | input | 2 | Pull-up length exponent (1, 2, 4 or 8 clocks) |
| pu_off | input | 1 | 1 suppresses the pull-up enable |
| pin_in | input | 1 | Raw tamper pin |
| pu_en | output | 1 | Pull-up enable for the pin pad |
| flag_clr | input | 1 | Clears the tamper flag |
| tamper_flag | output | 1 | Sticky tamper flag |
| wr_en | input | 1 | Backup register write strobe |
| wr_addr | input | AW | Backup register write index |
| wr_data | input | DATA_W | Backup register write data |
| rd_addr | input | AW | Backup register read index |
| rd_data | output | DATA_W | Backup register read data |

## Verification
The assertions rely on two conditions:
- `filt_sel` and `pol` change only while `det_en` is low, so the consecutive count is never left above a newly chosen threshold.
- Backup indices stay below the register count.

The stimulus meets both conditions. It disables detection, waits several clocks, reprograms the settings and only then re-enables detection. It uses only the four valid indices of the default bank. The bench moves the pin only between sample cycles. It aligns each sampled run to the observed fall of `pu_en`, so every sample it counts is one the design also counted.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    FILT_EDGE = 2'd0,
    FILT_2    = 2'd1,
    FILT_4    = 2'd2,
    FILT_8    = 2'd3
  } filt_e;

  localparam int RUN_W = 4;

  function automatic logic [RUN_W-1:0] run_need(input filt_e m);
    case (m)
      FILT_2:  run_need = RUN_W'(2);
      FILT_4:  run_need = RUN_W'(4);
      FILT_8:  run_need = RUN_W'(8);
      default: run_need = RUN_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tg_sample_timer.sv
module tg_sample_timer #(
  parameter int RATE_BASE = 8,
  localparam int CNT_W = RATE_BASE + 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic [1:0] pch_sel,
  output logic       smp,
  output logic       pch_win
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask, phase, plen, pch_lo;

  // free-running base counter; each interval is a power-of-two slice of it
  always_comb cnt_d = cnt_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    mask    = (ONE << (CNT_W'(RATE_BASE) + CNT_W'(rate_sel))) - ONE;
    phase   = cnt_q & mask;
    plen    = ONE << pch_sel;
    pch_lo  = mask - plen;
    smp     = (phase == mask);
    pch_win = (phase >= pch_lo) && (phase != mask);
  end
endmodule

// File: rtl/tg_level_filter.sv
module tg_level_filter
  import tg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  smp,
  input  logic  lvl_ok,
  input  filt_e mode,
  output logic  hit
);
  logic [RUN_W-1:0] run_q, run_d, need, incr;
  logic             run_en;

  always_comb begin
    need   = run_need(mode);
    incr   = run_q + RUN_W'(1);
    run_en = clear | smp;
    hit    = smp & lvl_ok & ~clear & (incr >= need);
    if (clear)       run_d = '0;
    else if (!lvl_ok) run_d = '0;
    else if (incr >= need) run_d = need;
    else             run_d = incr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assert_miss_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp && !lvl_ok) |=> (run_q == '0));
endmodule

// File: rtl/tg_backup_bank.sv
module tg_backup_bank #(
  parameter int NUM_BKP = 4,
  parameter int DATA_W  = 32,
  parameter int AW      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [NUM_BKP];
  logic              bank_nz;

  for (genvar i = 0; i < NUM_BKP; i++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] nxt;
    always_comb begin
      we  = wr_en & (wr_addr == AW'(i));
      // erase dominates any write landing in the same cycle
      nxt = wipe ? '0 : wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs_q[i] <= '0;
      else if (wipe | we)  regs_q[i] <= nxt;
    end
  end

  always_comb rd_data = regs_q[rd_addr];

  always_comb begin
    bank_nz = 1'b0;
    for (int k = 0; k < NUM_BKP; k++) bank_nz = bank_nz | (|regs_q[k]);
  end

  assert_wipe_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !bank_nz);

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wipe) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
#(
  parameter int RATE_BASE = 8,
  parameter int NUM_BKP   = 4,
  parameter int DATA_W    = 32,
  localparam int AW       = (NUM_BKP > 1) ? $clog2(NUM_BKP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_en,
  input  logic [1:0]        filt_sel,
  input  logic              pol,
  input  logic [2:0]        rate_sel,
  input  logic [1:0]        pch_sel,
  input  logic              pu_off,
  input  logic              pin_in,
  output logic              pu_en,
  input  logic              flag_clr,
  output logic              tamper_flag,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // pin synchronizer and previous-value register for transition detect
  logic pin_s, prev_q, prev_d;

  tg_sync #(.STAGES(2)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  always_comb prev_d = pin_s;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) prev_q <= 1'b0;
    else             prev_q <= prev_d;
  end

  // mode decode
  filt_e mode;
  logic  level_mode, lvl_active, lvl_ok;

  always_comb begin
    mode       = filt_e'(filt_sel);
    level_mode = (mode != FILT_EDGE);
    lvl_active = det_en & level_mode;
    lvl_ok     = pin_s ^ pol;
  end

  // sample timing
  logic smp, pch_win;

  tg_sample_timer #(.RATE_BASE(RATE_BASE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rate_sel (rate_sel),
    .pch_sel  (pch_sel),
    .smp      (smp),
    .pch_win  (pch_win)
  );

  // consecutive-sample filter
  logic lvl_hit;

  tg_level_filter u_filter (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clear  (~lvl_active),
    .smp    (smp),
    .lvl_ok (lvl_ok),
    .mode   (mode),
    .hit    (lvl_hit)
  );

  // event combine
  logic edge_hit, tamper_hit;

  always_comb begin
    edge_hit   = det_en & ~level_mode &
                 (pol ? (prev_q & ~pin_s) : (pin_s & ~prev_q));
    tamper_hit = edge_hit | lvl_hit;
    pu_en      = lvl_active & ~pu_off & pch_win;
  end

  // sticky flag: a new event overrides a clear request
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = tamper_hit | flag_clr;
    flag_d  = tamper_hit;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign tamper_flag = flag_q;

  // backup storage
  tg_backup_bank #(.NUM_BKP(NUM_BKP), .DATA_W(DATA_W), .AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wipe    (tamper_hit),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assert_hit_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    tamper_hit |=> tamper_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tamper_flag && !flag_clr) |=> tamper_flag);
endmodule

// File: tb/tamper_guard_bench.sv
module tamper_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RB  = 4;
  localparam int NB  = 4;
  localparam int DW  = 32;
  localparam int AWB = 2;

  logic clk, rst_n, det_en, pol, pu_off, pin_in, pu_en, flag_clr, tamper_flag, wr_en;
  logic [1:0] filt_sel, pch_sel;
  logic [2:0] rate_sel;
  logic [AWB-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tamper_guard #(.RATE_BASE(RB), .NUM_BKP(NB), .DATA_W(DW)) u_tamper_guard (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .filt_sel(filt_sel), .pol(pol),
    .rate_sel(rate_sel), .pch_sel(pch_sel), .pu_off(pu_off), .pin_in(pin_in),
    .pu_en(pu_en), .flag_clr(flag_clr), .tamper_flag(tamper_flag),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // transition mode run for one polarity
  task automatic edge_run(input bit p);
    bit a;
    int pu_bad;
    a = ~p;
    det_en = 0; filt_sel = 2'd0; pol = p; pu_off = 0; pin_in = a;
    repeat (5) @(negedge clk);
    det_en = 1;
    clear_flag();
    repeat (3) @(negedge clk);
    pin_in = ~a;                          // wrong transition
    pu_bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (pu_en) pu_bad++;
    end
    chk(tamper_flag == 1'b0, "R1 opposite edge ignored", tamper_flag, 0);
    chk(pu_bad == 0, "R3 pull-up idle in transition mode", pu_bad, 0);
    pin_in = a;                           // active transition
    repeat (2) @(negedge clk);
    chk(tamper_flag == 1'b0, "R2 flag not before third edge", tamper_flag, 0);
    @(negedge clk);
    chk(tamper_flag == 1'b1, "R1 R2 active edge sets flag", tamper_flag, 1);
    det_en = 0;
  endtask

  // sampled mode run with one restart injected
  task automatic level_run(input int f, input bit p, input int r, input int pc);
    int need, period, plen, i, modcnt, w, last, cyc, timeout, total;
    bit fmodel, act, prev_pu;
    det_en = 0; filt_sel = 2'(f); pol = p; rate_sel = 3'(r); pch_sel = 2'(pc);
    pu_off = 0; pin_in = p;
    clear_flag();
    repeat (4) @(negedge clk);
    need = 1 << f; period = 1 << (RB + r); plen = 1 << pc;
    total = 2 * need + 2;
    timeout = (total + 2) * period + 20;
    i = 0; modcnt = 0; fmodel = 0; act = 0; prev_pu = 0; w = 0; last = 0; cyc = 0;
    det_en = 1;
    while (i < total && cyc < timeout) begin
      @(negedge clk);
      cyc++;
      if (prev_pu && !pu_en) begin
        if (i >= 1) begin
          chk(w == plen, "R7 pull-up length", w, plen);
          chk(cyc - last == period, "R6 sample interval", cyc - last, period);
        end
        chk(tamper_flag == fmodel, "R4 R5 flag after run", tamper_flag, fmodel);
        if (act) begin
          modcnt++;
          if (modcnt >= need) fmodel = 1;
        end else modcnt = 0;
        if (i == 0) act = 1;
        else if (i == need - 1) act = 0;
        else if (i == need) act = 1;
        pin_in = act ? ~p : p;
        last = cyc; w = 0; i++;
      end
      if (pu_en) w++;
      prev_pu = pu_en;
    end
    chk(cyc < timeout, "R6 samples observed", cyc, timeout);
    @(negedge clk);
    chk(tamper_flag == 1'b1, "R4 flag set after full run", tamper_flag, 1);
    det_en = 0;
  endtask

  initial begin
    int pu_bad;
    rst_n = 0; det_en = 0; filt_sel = 0; pol = 0; rate_sel = 0; pch_sel = 0;
    pu_off = 0; pin_in = 0; flag_clr = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    chk(tamper_flag == 1'b0, "R12 flag in reset", tamper_flag, 0);
    chk(pu_en == 1'b0, "R12 pull-up in reset", pu_en, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NB; k++) begin
      rd_addr = AWB'(k); #1;
      chk(rd_data == '0, "R12 backup zero after reset", rd_data, 0);
    end

    // R10 write and read back
    for (int k = 0; k < NB; k++) begin
      wr_en = 1; wr_addr = AWB'(k); wr_data = DW'(32'hA5000000 + k * 32'h1111);
      @(negedge clk);
    end
    wr_en = 0;
    for (int k = 0; k < NB; k++) begin
      rd_addr = AWB'(k); #1;
      chk(rd_data == DW'(32'hA5000000 + k * 32'h1111), "R10 read back", rd_data,
          32'hA5000000 + k * 32'h1111);
    end

    // R11 disabled detection
    filt_sel = 0; pol = 0; pin_in = 0;
    repeat (4) @(negedge clk);
    pin_in = 1;
    repeat (6) @(negedge clk);
    chk(tamper_flag == 1'b0, "R11 transition ignored when disabled", tamper_flag, 0);
    filt_sel = 1; rate_sel = 0; pch_sel = 1; pin_in = 1;
    pu_bad = 0;
    for (int c = 0; c < 4 * (1 << RB); c++) begin
      @(negedge clk);
      if (pu_en) pu_bad++;
    end
    chk(tamper_flag == 1'b0, "R11 level ignored when disabled", tamper_flag, 0);
    chk(pu_bad == 0, "R3 pull-up idle when disabled", pu_bad, 0);

    // R9 tamper erase colliding with a write
    filt_sel = 0; pol = 0; pin_in = 0;
    repeat (4) @(negedge clk);
    det_en = 1;
    clear_flag();
    pin_in = 1;
    repeat (2) @(negedge clk);
    wr_en = 1; wr_addr = 2'd1; wr_data = 32'hDEADBEEF;
    @(negedge clk);
    wr_en = 0;
    chk(tamper_flag == 1'b1, "R9 flag with erase", tamper_flag, 1);
    for (int k = 0; k < NB; k++) begin
      rd_addr = AWB'(k); #1;
      chk(rd_data == '0, "R9 erase beats write", rd_data, 0);
    end

    // R8 sticky flag and clear
    repeat (10) @(negedge clk);
    chk(tamper_flag == 1'b1, "R8 flag sticky", tamper_flag, 1);
    clear_flag();
    chk(tamper_flag == 1'b0, "R8 flag cleared", tamper_flag, 0);
    det_en = 0;

    edge_run(1'b0);
    edge_run(1'b1);

    // R3 pull-up suppressed in sampled mode
    filt_sel = 1; pol = 0; rate_sel = 0; pch_sel = 2; pin_in = 1; pu_off = 1;
    clear_flag();
    repeat (4) @(negedge clk);
    det_en = 1;
    pu_bad = 0;
    for (int c = 0; c < 4 * (1 << RB) + 10; c++) begin
      @(negedge clk);
      if (pu_en) pu_bad++;
    end
    chk(pu_bad == 0, "R3 pull-up off by control", pu_bad, 0);
    chk(tamper_flag == 1'b1, "R4 sampled event without pull-up", tamper_flag, 1);
    det_en = 0; pu_off = 0;

    for (int p = 0; p < 2; p++)
      for (int f = 1; f < 4; f++)
        for (int r = 0; r < 3; r++)
          for (int pc = 0; pc < 4; pc++)
            level_run(f, p[0], r, pc);
    for (int r = 3; r < 8; r++) level_run(1, 1'b0, r, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule